// File: doc/BRIEF.md
# Multi-lane SPI shift engine

This block is the serial datapath of a half-duplex SPI master. A word-level request carries either a word to send or a request to receive one. The engine serialises it over one, two or four data lanes, depending on a lane-mode setting that can change between words. It produces a serial clock from the system clock through a programmable divider, with selectable idle polarity and sampling phase. In receive mode it captures the incoming lanes, rebuilds the parallel word and can reverse its byte order before presenting it.

Per-lane output enables let the data pins be shared in both directions. Enables are raised only on the lanes a write uses and are all dropped for a read. The settings are captured when a request is accepted, so software may change them for the next word while the current one is still shifting. Chip-select control and transaction counting sit outside this block.

Top module: `spi_lane_engine`

## Requirements
- R1: After reset `busy`=0, `cmd_ready`=1, `rx_valid`=0, `rx_data`=0, `sdo_en`=0, `sdo`=0 and `sck` equals `cfg_cpol`.
- R2: A request is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle `busy`=1 and `cmd_ready`=0 until the word is finished. All settings (`cfg_*`, `cmd_read`, `cmd_data`) are captured at that edge, and later changes have no effect on the word in flight.
- R3: `cfg_lanes` sets the lane count. 00 selects one lane: data goes out on lane 0 and is sampled from lane 1. 01 selects two lanes (0 and 1). 10 and 11 both select four lanes (0 to 3). Unused input lanes are ignored.
- R4: Word size for a write comes from `cfg_tx_size` and for a read from `cfg_rx_size`: 00=8, 01=16, 10=24, 11=32 bits. Words are right-aligned in `cmd_data` and `rx_data`. Unused upper bits of `cmd_data` are ignored, and unused upper bits of `rx_data` are 0.
- R5: Each beat moves one group of bits, one bit per active lane, and lane i carries bit (base+i) of the word. With `cfg_lsb_first`=0 the groups run from the top of the word down, so the first base is bits-lanes. With `cfg_lsb_first`=1 they run from bit 0 up.
- R6: Every serial clock half-period lasts `cfg_div`+1 system clocks. A beat is two half-periods. `busy` stays high for exactly 2*(`cfg_div`+1)*bits/lanes cycles.
- R7: While idle, `sck` equals `cfg_cpol`. During a word, the first half of each beat drives `sck` = `cfg_cpol` XOR `cfg_cpha` and the second half drives its inverse. Input lanes are captured at the clock edge that ends the first half. `sdo` changes only at beat boundaries.
- R8: During a write, `sdo_en` has a 1 for each active lane: 0001 for one lane, 0011 for two, 1111 for four. During a read and while idle, `sdo_en`=0000. `sdo` is 0 on every lane whose enable is 0.
- R9: After a read, `rx_valid` is 1 for exactly one cycle, the first cycle in which `busy` is 0 again, and `rx_data` then holds the word. `rx_data` is held until the next read ends. A write never raises `rx_valid` and does not change `rx_data`.
- R10: With `cfg_byte_rev`=1 the bytes of a received word are reversed within its size: byte k moves to byte (bytes-1-k). With 0 the word is delivered unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lanes | input | 2 | Lane mode: 00 one, 01 two, 10/11 four |
| cfg_tx_size | input | 2 | Write word size (8/16/24/32) |
| cfg_rx_size | input | 2 | Read word size (8/16/24/32) |
| cfg_lsb_first | input | 1 | 1 = least significant group first |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 1 = capture on the second edge of a beat |
| cfg_div | input | 16 | Half-period length minus one, in system clocks |
| cfg_byte_rev | input | 1 | Reverse byte order of received words |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Engine idle and able to take a request |
| cmd_read | input | 1 | 1 = receive a word, 0 = send `cmd_data` |
| cmd_data | input | 32 | Word to send, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | 32 | Received word, right-aligned |
| sck | output | 1 | Serial clock |
| sdo | output | 4 | Per-lane output data |
| sdo_en | output | 4 | Per-lane output enable |
| sdi | input | 4 | Per-lane input data |
| busy | output | 1 | A word is being shifted |

## Verification
The bench predicts `sck`, `sdo`, `sdo_en` and `busy` for every cycle of each word and sweeps all lane modes, word sizes, directions, polarities and phases. It scrambles the live settings right after acceptance, so a design that failed to capture them would show a wrong clock length or bit order mid-word. Reads drive random values on unused lanes and in one-lane mode put data only on lane 1, which exposes a design that samples the wrong pin or mixes in idle lanes. Byte reversal for 24-bit words is included, because a design that always reverses four bytes would deliver a shifted, zero-padded value. A very long divider and a zero divider catch an off-by-one in the half-period count.

// File: rtl/spi_lane_pkg.sv
`timescale 1ns/1ps
package spi_lane_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = 4;
    localparam int BYTES  = WORD_W / 8;
    localparam int BEAT_W = $clog2(WORD_W) + 1;
    localparam int LSH_W  = 2;

    typedef enum logic [1:0] {
        LM_ONE      = 2'b00,
        LM_TWO      = 2'b01,
        LM_FOUR     = 2'b10,
        LM_FOUR_ALT = 2'b11
    } lane_mode_e;

    typedef enum logic [1:0] {
        WS_8  = 2'b00,
        WS_16 = 2'b01,
        WS_24 = 2'b10,
        WS_32 = 2'b11
    } word_size_e;

    // settings frozen at request acceptance
    typedef struct packed {
        logic [LSH_W-1:0] lane_shift;
        logic             lsb_first;
        logic             lead_level;
        logic             byte_rev;
        logic             read;
        word_size_e       rx_size;
    } xfer_cfg_t;

    function automatic logic [LSH_W-1:0] mode_to_shift(input lane_mode_e m);
        case (m)
            LM_ONE:  return 2'd0;
            LM_TWO:  return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic int lanes_of(input logic [LSH_W-1:0] lsh);
        return 1 << lsh;
    endfunction

    function automatic int bits_of(input word_size_e s);
        return 8 * (int'(s) + 1);
    endfunction

    function automatic logic [BEAT_W-1:0] beats_of(input word_size_e s, input logic [LSH_W-1:0] lsh);
        return BEAT_W'(bits_of(s) >> lsh);
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic [LSH_W-1:0] lsh);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) m[i] = (i < lanes_of(lsh));
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] byte_swap(input logic [WORD_W-1:0] w, input word_size_e s);
        logic [WORD_W-1:0] r;
        int nb;
        r  = '0;
        nb = int'(s) + 1;
        for (int i = 0; i < BYTES; i++)
            if (i < nb) r[8*(nb-1-i) +: 8] = w[8*i +: 8];
        return r;
    endfunction
endpackage

// File: rtl/spi_half_timer.sv
`timescale 1ns/1ps
module spi_half_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             phase_b,
    output logic             sample_stb,
    output logic             shift_stb
);
    logic [DIV_W-1:0] cnt_q;
    logic             ph_q;
    logic             half_end;

    assign half_end = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (run) begin
            if (half_end) begin
                cnt_q <= '0;
                ph_q  <= ~ph_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase_b    = ph_q;
    assign sample_stb = half_end & ~ph_q;
    assign shift_stb  = half_end & ph_q;

    // R6: the clock half only flips once the count reaches the divider
    a_r6_half_hold: assert property (@(posedge clk) disable iff (rst)
        (run && !start && !half_end) |=> $stable(ph_q));
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= div));
endmodule

// File: rtl/spi_tx_shifter.sv
`timescale 1ns/1ps
module spi_tx_shifter
    import spi_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] load_data,
    input  word_size_e        load_size,
    input  logic              load_lsb,
    input  logic              lsb_first,
    input  logic [LSH_W-1:0]  lane_shift,
    output logic [LANES-1:0]  lane_out
);
    logic [WORD_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load) begin
            // MSB-first words are left-aligned so the head group sits at the top
            sr_q <= load_lsb ? load_data : (load_data << (WORD_W - bits_of(load_size)));
        end else if (shift) begin
            sr_q <= lsb_first ? (sr_q >> lanes_of(lane_shift)) : (sr_q << lanes_of(lane_shift));
        end
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic pick;
            always_comb begin
                if (g < lanes_of(lane_shift))
                    pick = lsb_first ? sr_q[g] : sr_q[WORD_W - lanes_of(lane_shift) + g];
                else
                    pick = 1'b0;
            end
            assign lane_out[g] = pick;
        end
    endgenerate
endmodule

// File: rtl/spi_rx_assembler.sv
`timescale 1ns/1ps
module spi_rx_assembler
    import spi_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic              finish,
    input  logic [LANES-1:0]  lanes_in,
    input  logic [LSH_W-1:0]  lane_shift,
    input  logic              lsb_first,
    input  logic              byte_rev,
    input  word_size_e        rx_size,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);
    logic [WORD_W-1:0] acc_q;
    logic [LANES-1:0]  grp;
    logic [WORD_W-1:0] grp_w;
    logic [WORD_W-1:0] aligned;
    logic [WORD_W-1:0] shaped;

    always_comb begin
        grp = '0;
        case (lane_shift)
            2'd0:    grp[0]   = lanes_in[1];
            2'd1:    grp[1:0] = lanes_in[1:0];
            default: grp      = lanes_in;
        endcase
        grp_w   = WORD_W'(grp);
        aligned = lsb_first ? (acc_q >> (WORD_W - bits_of(rx_size))) : acc_q;
        shaped  = byte_rev ? byte_swap(aligned, rx_size) : aligned;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else if (sample) begin
            if (lsb_first)
                acc_q <= (acc_q >> lanes_of(lane_shift)) | (grp_w << (WORD_W - lanes_of(lane_shift)));
            else
                acc_q <= (acc_q << lanes_of(lane_shift)) | grp_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= finish;
            if (finish) word_data <= shaped;
        end
    end

    // R9: a received word is announced for a single cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);
endmodule

// File: rtl/spi_lane_engine.sv
`timescale 1ns/1ps
module spi_lane_engine
    import spi_lane_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_lanes,
    input  logic [1:0]        cfg_tx_size,
    input  logic [1:0]        cfg_rx_size,
    input  logic              cfg_lsb_first,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_byte_rev,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_read,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data,
    output logic              sck,
    output logic [LANES-1:0]  sdo,
    output logic [LANES-1:0]  sdo_en,
    input  logic [LANES-1:0]  sdi,
    output logic              busy
);
    xfer_cfg_t         cfg_q;
    logic [DIV_W-1:0]  div_q;
    logic              busy_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] last_q;
    logic              accept;
    logic              done;
    logic              phase_b;
    logic              sample_stb;
    logic              shift_stb;
    logic [LSH_W-1:0]  new_lsh;
    word_size_e        sel_size;
    logic [LANES-1:0]  tx_lanes;
    logic [LANES-1:0]  en_mask;

    assign accept   = cmd_valid && !busy_q;
    assign new_lsh  = mode_to_shift(lane_mode_e'(cfg_lanes));
    assign sel_size = word_size_e'(cmd_read ? cfg_rx_size : cfg_tx_size);
    assign done     = shift_stb && (beat_q == last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cfg_q  <= '0;
            div_q  <= '0;
            beat_q <= '0;
            last_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cfg_q  <= '{lane_shift: new_lsh,
                        lsb_first:  cfg_lsb_first,
                        lead_level: cfg_cpol ^ cfg_cpha,
                        byte_rev:   cfg_byte_rev,
                        read:       cmd_read,
                        rx_size:    word_size_e'(cfg_rx_size)};
            div_q  <= cfg_div;
            beat_q <= '0;
            last_q <= beats_of(sel_size, new_lsh) - 1'b1;
        end else if (shift_stb) begin
            if (done) busy_q <= 1'b0;
            else      beat_q <= beat_q + 1'b1;
        end
    end

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .run        (busy_q),
        .div        (div_q),
        .phase_b    (phase_b),
        .sample_stb (sample_stb),
        .shift_stb  (shift_stb)
    );

    spi_tx_shifter u_tx (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .shift      (shift_stb),
        .load_data  (cmd_data),
        .load_size  (sel_size),
        .load_lsb   (cfg_lsb_first),
        .lsb_first  (cfg_q.lsb_first),
        .lane_shift (cfg_q.lane_shift),
        .lane_out   (tx_lanes)
    );

    spi_rx_assembler u_rx (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .sample     (sample_stb),
        .finish     (done && cfg_q.read),
        .lanes_in   (sdi),
        .lane_shift (cfg_q.lane_shift),
        .lsb_first  (cfg_q.lsb_first),
        .byte_rev   (cfg_q.byte_rev),
        .rx_size    (cfg_q.rx_size),
        .word_valid (rx_valid),
        .word_data  (rx_data)
    );

    assign en_mask   = (busy_q && !cfg_q.read) ? lane_mask(cfg_q.lane_shift) : '0;
    assign sdo_en    = en_mask;
    assign sdo       = tx_lanes & en_mask;
    assign sck       = busy_q ? (cfg_q.lead_level ^ phase_b) : cfg_cpol;
    assign cmd_ready = !busy_q;
    assign busy      = busy_q;

    // R2: an accepted request makes the engine busy on the next cycle
    a_r2_accept_starts: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));
    // R3: the beat index never passes the last beat of the word
    a_r3_beat_bound: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (beat_q <= last_q));
    // R7: output data moves only on beat boundaries
    a_r7_sdo_beat_stable: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !shift_stb) |=> $stable(sdo));
    // R9: a received word follows a read that has just ended
    a_r9_rx_after_read: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (!busy_q && cfg_q.read && $past(busy_q)));
endmodule

// File: tb/spi_lane_engine_bench.sv
`timescale 1ns/1ps
module spi_lane_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_lanes = 2'b00;
    logic [1:0]  cfg_tx_size = 2'b00;
    logic [1:0]  cfg_rx_size = 2'b00;
    logic        cfg_lsb_first = 1'b0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic [15:0] cfg_div = 16'd0;
    logic        cfg_byte_rev = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [31:0] cmd_data = 32'd0;
    logic [3:0]  sdi = 4'd0;
    logic        cmd_ready;
    logic        rx_valid;
    logic [31:0] rx_data;
    logic        sck;
    logic [3:0]  sdo;
    logic [3:0]  sdo_en;
    logic        busy;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] last_rx = 32'd0;

    always #2.5 clk = ~clk;

    spi_lane_engine u_spi_lane_engine (
        .clk(clk), .rst(rst),
        .cfg_lanes(cfg_lanes), .cfg_tx_size(cfg_tx_size), .cfg_rx_size(cfg_rx_size),
        .cfg_lsb_first(cfg_lsb_first), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_div(cfg_div), .cfg_byte_rev(cfg_byte_rev),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read), .cmd_data(cmd_data),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .sck(sck), .sdo(sdo), .sdo_en(sdo_en), .sdi(sdi), .busy(busy)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One word, modelled cycle by cycle from the requirements
    task automatic xfer(input logic [1:0] mode, input logic [1:0] size, input bit rd,
                        input bit lsb, input bit cpol, input bit cpha, input int div,
                        input bit rev, input logic [31:0] word);
        int nl, nb, beats, h, b, base;
        bit second;
        logic [3:0]  e_sdo, e_en, d;
        logic [31:0] e_rx;
        nl    = (mode == 2'd0) ? 1 : (mode == 2'd1) ? 2 : 4;
        nb    = 8 * (int'(size) + 1);
        beats = nb / nl;
        h     = div + 1;
        e_rx  = '0;
        for (int k = 0; k < nb / 8; k++)
            e_rx[8*k +: 8] = rev ? word[8*(nb/8-1-k) +: 8] : word[8*k +: 8];

        @(negedge clk);
        cfg_lanes     = mode;
        cfg_tx_size   = rd ? ~size : size;   // R4: the other direction's size must not matter
        cfg_rx_size   = rd ? size : ~size;
        cfg_lsb_first = lsb;
        cfg_cpol      = cpol;
        cfg_cpha      = cpha;
        cfg_div       = 16'(div);
        cfg_byte_rev  = rev;
        cmd_valid     = 1'b1;
        cmd_read      = rd;
        cmd_data      = rd ? ~word : word;
        sdi           = 4'd0;
        #1;
        chk("R2", "ready before accept", {31'd0, cmd_ready}, 32'd1);
        chk("R7", "idle clock level", {31'd0, sck}, {31'd0, cpol});

        @(negedge clk);
        // R2: scramble live settings; the word in flight must not notice
        cmd_valid     = 1'b0;
        cmd_data      = ~cmd_data;
        cfg_lanes     = ~mode;
        cfg_lsb_first = ~lsb;
        cfg_div       = 16'(div + 2);
        cfg_tx_size   = ~cfg_tx_size;
        cfg_rx_size   = ~cfg_rx_size;
        cfg_byte_rev  = ~rev;

        for (int c = 0; c < beats * 2 * h; c++) begin
            b      = c / (2 * h);
            second = ((c % (2 * h)) >= h);
            base   = lsb ? nl * b : nb - nl * (b + 1);
            e_sdo  = '0;
            e_en   = '0;
            d      = 4'($urandom);
            for (int i = 0; i < nl; i++) begin
                if (!rd) begin
                    e_en[i]  = 1'b1;
                    e_sdo[i] = word[base + i];
                end else if (nl == 1) begin
                    d[1] = word[base];
                end else begin
                    d[i] = word[base + i];
                end
            end
            sdi = d;
            #1;
            chk("R6", "busy during word", {31'd0, busy}, 32'd1);
            chk("R2", "ready while busy", {31'd0, cmd_ready}, 32'd0);
            chk("R7", "clock level", {31'd0, sck}, {31'd0, cpol ^ cpha ^ second});
            chk("R8", "output enable", {28'd0, sdo_en}, {28'd0, e_en});
            chk("R5", "lane data", {28'd0, sdo}, {28'd0, e_sdo});
            chk("R9", "no strobe mid word", {31'd0, rx_valid}, 32'd0);
            @(negedge clk);
        end

        sdi = 4'd0;
        #1;
        chk("R6", "busy drops after length", {31'd0, busy}, 32'd0);
        chk("R7", "clock back to idle", {31'd0, sck}, {31'd0, cpol});
        chk("R8", "enables off when idle", {28'd0, sdo_en}, 32'd0);
        chk("R9", "strobe after read only", {31'd0, rx_valid}, {31'd0, rd});
        if (rd) begin
            if (rev) chk("R10", "byte reversed word", rx_data, e_rx);
            else     chk("R4", "received word R3", rx_data, e_rx);
            last_rx = e_rx;
        end else begin
            chk("R9", "write keeps rx_data", rx_data, last_rx);
        end
        @(negedge clk);
        #1;
        chk("R9", "strobe lasts one cycle", {31'd0, rx_valid}, 32'd0);
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cfg_cpol = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "busy after reset", {31'd0, busy}, 32'd0);
        chk("R1", "ready after reset", {31'd0, cmd_ready}, 32'd1);
        chk("R1", "strobe after reset", {31'd0, rx_valid}, 32'd0);
        chk("R1", "rx_data after reset", rx_data, 32'd0);
        chk("R1", "enables after reset", {28'd0, sdo_en}, 32'd0);
        chk("R1", "data after reset", {28'd0, sdo}, 32'd0);
        chk("R1", "clock after reset", {31'd0, sck}, 32'd1);

        for (int idx = 0; idx < 32; idx++)
            xfer(2'(idx), 2'(idx >> 2), idx[4], (idx % 3) == 1, ((idx / 2) % 2) == 1,
                 ((idx / 3) % 2) == 1, idx % 3, ((idx / 5) % 2) == 1, $urandom);

        xfer(2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 300, 1'b0, 32'hA5C3_0F81);
        xfer(2'd0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b1, 32'h1234_5678);
        xfer(2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b1, 32'h00AB_CDEF);
        xfer(2'd3, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1, 1'b0, 32'hF00D_CAFE);
        xfer(2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 2, 1'b0, 32'hFFFF_9C3A);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule